// File: doc/BRIEF.md
# Posted-Write Buffer for a Write-Through Cache

This block sits between a write-through cache and main memory. It takes CPU store requests, each an address and a data word, and queues them in a small first-in first-out store. The store is acknowledged to the CPU in the same cycle the entry is taken in, so the CPU does not wait for memory. The CPU can go on to later work, such as read hits served by the cache, while the buffer drains its entries to memory one at a time in arrival order. As a result, write hits and write misses both finish at cache speed, and only read misses pay the memory latency.

A read miss travels through the same memory port. Before the read is issued, the block first drains every queued write. The value returned therefore always reflects stores the CPU has already been told are done. While a read miss is outstanding, new stores are held off. An entry leaves the buffer only when memory acknowledges its write, and the block reports whether the buffer is empty or full.

Top module: `postwr_buffer`

## Requirements
- R1: While reset is held, and right after it, bufEmpty is 1, bufFull is 0, memReq is 0 and cpuWrAck is 0.
- R2: When the buffer is not full and cpuRdMiss is low, cpuWrAck goes high combinationally in the same cycle cpuWrReq is presented. This holds even while a memory transaction is still outstanding. The entry is taken in at that clock edge.
- R3: Each accepted store is issued to memory exactly once, with memWe=1 and its own address and data, in the order the stores were accepted. The buffer issues no write while it is empty.
- R4: The buffer holds DEPTH entries (4 by default). cpuWrAck is withheld only while bufFull is 1. A stalled store is accepted once an entry has drained.
- R5: An entry is freed only in a cycle where memReq, memWe and memAck are all 1. bufFull therefore stays 1 until such a cycle, and bufEmpty and bufFull are never 1 together.
- R6: A read miss is issued to memory (memReq=1, memWe=0) only after the buffer is empty. The data it returns reflects every store accepted before it.
- R7: A read transaction drives memAddr=cpuRdAddr with memWe=0. cpuRdDone is high exactly in the cycle memAck completes it, and cpuRdData then carries memRData.
- R8: While cpuRdMiss is high, cpuWrAck stays 0.
- R9: Once memReq is raised, memReq, memWe, memAddr and (for writes) memWData hold steady until memAck.
- R10: A read miss that finds the buffer empty goes straight to memory and returns the current memory value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrReq | input | 1 | CPU store request, held until cpuWrAck |
| cpuWrAddr | input | AW | Store address |
| cpuWrData | input | DW | Store data |
| cpuWrAck | output | 1 | Store accepted into the buffer this cycle |
| cpuRdMiss | input | 1 | Read miss request, held until cpuRdDone |
| cpuRdAddr | input | AW | Read miss address |
| cpuRdData | output | DW | Read miss data, valid with cpuRdDone |
| cpuRdDone | output | 1 | Read miss completes this cycle |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Memory address |
| memWData | output | DW | Memory write data |
| memRData | input | DW | Memory read data, valid with memAck |
| memAck | input | 1 | Memory completes the transaction this cycle |
| bufEmpty | output | 1 | No entries queued |
| bufFull | output | 1 | All DEPTH entries occupied |

## Verification
The bench builds the block with DEPTH=4, AW=8 and DW=16. Four entries are few enough that a memory model with a long latency fills the buffer within a handful of stores, which exposes both the full stall and the rule that an entry is freed only on acknowledge. The memory latency is changed from test to test. A short latency checks drain order, including a repeated address where the later store must win. A long latency keeps a read miss waiting behind queued writes, while a store is presented at the same time.

// File: rtl/postwr_pkg.sv
package postwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } drainState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;     // take the CPU store into the tail entry
    logic pop;      // retire the head entry
    logic selRead;  // memory address from the read miss, not the head
  } bufStrobe_t;

endpackage

// File: rtl/postwr_data.sv
module postwr_data
  import postwr_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  bufStrobe_t    strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWData,
  output logic          empty,
  output logic          full
);

  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [PTRW-1:0] LASTPTR = PTRW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULLCNT = CNTW'(DEPTH);

  logic [AW-1:0]   addrStore [DEPTH];
  logic [DW-1:0]   dataStore [DEPTH];
  logic [PTRW-1:0] headPtr;
  logic [PTRW-1:0] tailPtr;
  logic [CNTW-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrStore[tailPtr] <= wrAddr;
      dataStore[tailPtr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      fillCnt <= '0;
    end else begin
      if (strobe.push) tailPtr <= (tailPtr == LASTPTR) ? '0 : tailPtr + 1'b1;
      if (strobe.pop)  headPtr <= (headPtr == LASTPTR) ? '0 : headPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  assign empty    = (fillCnt == '0);
  assign full     = (fillCnt == FULLCNT);
  assign memAddr  = strobe.selRead ? rdAddr : addrStore[headPtr];
  assign memWData = dataStore[headPtr];

endmodule

// File: rtl/postwr_ctrl.sv
module postwr_ctrl
  import postwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrReq,
  input  logic       cpuRdMiss,
  input  logic       memAck,
  input  logic       bufEmpty,
  input  logic       bufFull,
  output bufStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       cpuWrAck,
  output logic       cpuRdDone
);

  drainState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        // queued writes always go first, so a read never sees stale memory
        if (!bufEmpty)      stateNext = ST_WRITE;
        else if (cpuRdMiss) stateNext = ST_READ;
      end
      ST_WRITE: if (memAck) stateNext = ST_IDLE;
      ST_READ:  if (memAck) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.push    = cpuWrReq && !bufFull && !cpuRdMiss;
    strobe.pop     = (state == ST_WRITE) && memAck;
    strobe.selRead = (state == ST_READ);
  end

  assign memReq    = (state != ST_IDLE);
  assign memWe     = (state == ST_WRITE);
  assign cpuWrAck  = strobe.push;
  assign cpuRdDone = (state == ST_READ) && memAck;

endmodule

// File: rtl/postwr_buffer.sv
module postwr_buffer
  import postwr_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuWrReq,
  input  logic [AW-1:0] cpuWrAddr,
  input  logic [DW-1:0] cpuWrData,
  output logic          cpuWrAck,
  input  logic          cpuRdMiss,
  input  logic [AW-1:0] cpuRdAddr,
  output logic [DW-1:0] cpuRdData,
  output logic          cpuRdDone,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWData,
  input  logic [DW-1:0] memRData,
  input  logic          memAck,
  output logic          bufEmpty,
  output logic          bufFull
);

  bufStrobe_t strobe;

  postwr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuWrReq  (cpuWrReq),
    .cpuRdMiss (cpuRdMiss),
    .memAck    (memAck),
    .bufEmpty  (bufEmpty),
    .bufFull   (bufFull),
    .strobe    (strobe),
    .memReq    (memReq),
    .memWe     (memWe),
    .cpuWrAck  (cpuWrAck),
    .cpuRdDone (cpuRdDone)
  );

  postwr_data #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrAddr   (cpuWrAddr),
    .wrData   (cpuWrData),
    .rdAddr   (cpuRdAddr),
    .memAddr  (memAddr),
    .memWData (memWData),
    .empty    (bufEmpty),
    .full     (bufFull)
  );

  assign cpuRdData = memRData;

endmodule

// File: rtl/postwr_buffer_chk.sv
module postwr_buffer_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuWrAck,
  input logic          cpuRdMiss,
  input logic          cpuRdDone,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWData,
  input logic          memAck,
  input logic          bufEmpty,
  input logic          bufFull
);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrAck |-> !bufFull);

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(bufFull && bufEmpty));

  // R5
  free_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !(memReq && memWe && memAck)) |=> bufFull);

  // R3
  no_empty_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> !(memReq && memWe));

  // R6
  read_after_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> bufEmpty);

  // R7
  read_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdDone |-> (memReq && !memWe && memAck));

  // R8
  read_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdMiss |-> !cpuWrAck);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)
                             && (!memWe || $stable(memWData))));

endmodule

bind postwr_buffer postwr_buffer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuWrAck  (cpuWrAck),
  .cpuRdMiss (cpuRdMiss),
  .cpuRdDone (cpuRdDone),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWData  (memWData),
  .memAck    (memAck),
  .bufEmpty  (bufEmpty),
  .bufFull   (bufFull)
);

// File: tb/postwr_buffer_bench.sv
module postwr_buffer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int NVEC = 6;

  // {address, data}; address 8'h21 appears twice, the later store must win
  localparam logic [AW+DW-1:0] VEC [NVEC] = '{
    {8'h10, 16'h1111}, {8'h21, 16'h2222}, {8'h32, 16'h3333},
    {8'h21, 16'h4444}, {8'h43, 16'h5555}, {8'h54, 16'h6666}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuWrReq = 1'b0;
  logic [AW-1:0] cpuWrAddr = '0;
  logic [DW-1:0] cpuWrData = '0;
  logic          cpuWrAck;
  logic          cpuRdMiss = 1'b0;
  logic [AW-1:0] cpuRdAddr = '0;
  logic [DW-1:0] cpuRdData;
  logic          cpuRdDone;
  logic          memReq;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWData;
  logic [DW-1:0] memRData = '0;
  logic          memAck = 1'b0;
  logic          bufEmpty;
  logic          bufFull;

  postwr_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_postwr_buffer (
    .clk(clk), .rstN(rstN),
    .cpuWrReq(cpuWrReq), .cpuWrAddr(cpuWrAddr), .cpuWrData(cpuWrData), .cpuWrAck(cpuWrAck),
    .cpuRdMiss(cpuRdMiss), .cpuRdAddr(cpuRdAddr), .cpuRdData(cpuRdData), .cpuRdDone(cpuRdDone),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memAck(memAck), .bufEmpty(bufEmpty), .bufFull(bufFull)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail = 0;

  // memory model and write log
  logic [DW-1:0] mem [256];
  logic [AW-1:0] logA [64];
  logic [DW-1:0] logD [64];
  int logN = 0;
  logic [AW-1:0] expA [64];
  logic [DW-1:0] expD [64];
  int expN = 0;
  int logChecked = 0;
  int memLat = 2;
  int waitCnt = 0;
  int stallBad = 0;
  int rdBlockBad = 0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i) ^ 16'hA5A5;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0;
      waitCnt = 0;
    end else if (memAck) begin
      memAck = 1'b0;
      waitCnt = 0;
    end else if (memReq) begin
      if (waitCnt >= memLat) begin
        memAck = 1'b1;
        if (memWe) begin
          mem[memAddr] = memWData;
          logA[logN] = memAddr;
          logD[logN] = memWData;
          logN++;
        end else begin
          memRData = mem[memAddr];
        end
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic cpuWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, output int waited);
    waited = 0;
    cpuWrReq = 1'b1; cpuWrAddr = a; cpuWrData = d;
    #1;
    while (!cpuWrAck) begin
      if (!bufFull && !cpuRdMiss) stallBad++;
      @(negedge clk); #1;
      waited++;
    end
    expA[expN] = a; expD[expN] = d; expN++;
    @(negedge clk);
    cpuWrReq = 1'b0;
  endtask

  task automatic cpuRead(input logic [AW-1:0] a, output logic [DW-1:0] d, output int logAtDone);
    cpuRdMiss = 1'b1; cpuRdAddr = a;
    #1;
    while (!cpuRdDone) begin
      if (cpuWrAck) rdBlockBad++;
      @(negedge clk); #1;
    end
    d = cpuRdData;
    logAtDone = logN;
    @(negedge clk);
    cpuRdMiss = 1'b0;
  endtask

  task automatic waitDrain();
    #1;
    while (!bufEmpty || memReq) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
  endtask

  // R3: compare the memory write log with the accepted stores
  task automatic checkLog();
    chk(logN == expN, "R3 write count", 32'(logN), 32'(expN));
    for (int i = logChecked; i < expN && i < logN; i++) begin
      chk(logA[i] == expA[i] && logD[i] == expD[i], "R3 drain order",
          {8'h0, logA[i], logD[i]}, {8'h0, expA[i], expD[i]});
    end
    logChecked = expN;
  endtask

  int w;
  int lw;
  logic [DW-1:0] rd;

  initial begin
    // R1: state during and right after reset
    @(negedge clk); #1;
    chk(bufEmpty == 1'b1, "R1 empty in reset", 32'(bufEmpty), 1);
    chk(bufFull == 1'b0, "R1 full in reset", 32'(bufFull), 0);
    chk(memReq == 1'b0, "R1 memReq in reset", 32'(memReq), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(bufEmpty == 1'b1 && bufFull == 1'b0 && memReq == 1'b0 && cpuWrAck == 1'b0,
        "R1 after reset", {bufEmpty, bufFull, memReq, cpuWrAck}, 32'h8);
    @(negedge clk);

    // R3: table of stores with a short memory latency
    memLat = 2;
    for (int i = 0; i < NVEC; i++) begin
      cpuWrite(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], w);
    end
    waitDrain();
    checkLog();
    cpuRead(8'h21, rd, lw);
    chk(rd == 16'h4444, "R6 repeated address keeps later store", 32'(rd), 32'h4444);

    // R2 / R4 / R5: long latency, fill the buffer
    memLat = 20;
    cpuWrite(8'h60, 16'hA001, w);
    chk(w == 0, "R2 ack immediate on empty buffer", 32'(w), 0);
    cpuWrite(8'h61, 16'hA002, w);
    chk(w == 0 && memReq == 1'b1, "R2 ack while memory busy", {w[15:0], 15'h0, memReq}, 32'h1);
    cpuWrite(8'h62, 16'hA003, w);
    cpuWrite(8'h63, 16'hA004, w);
    chk(w == 0, "R2 fourth store immediate", 32'(w), 0);
    #1;
    chk(bufFull == 1'b1 && bufEmpty == 1'b0, "R4 full after DEPTH stores",
        {bufFull, bufEmpty}, 32'h2);
    cpuWrite(8'h64, 16'hA005, w);
    chk(w > 5, "R4 fifth store stalled until drain", 32'(w), 6);
    chk(stallBad == 0, "R4 stall only while full", 32'(stallBad), 0);
    waitDrain();
    checkLog();
    chk(bufEmpty == 1'b1, "R5 empty after all acks", 32'(bufEmpty), 1);

    // R6 / R8: read miss behind queued stores with a concurrent store
    memLat = 10;
    cpuWrite(8'h70, 16'h1234, w);
    cpuWrite(8'h71, 16'h5678, w);
    cpuWrReq = 1'b1; cpuWrAddr = 8'h72; cpuWrData = 16'h9999;
    cpuRead(8'h71, rd, lw);
    chk(rd == 16'h5678, "R6 read returns buffered store", 32'(rd), 32'h5678);
    chk(lw == expN, "R6 read issued after drain", 32'(lw), 32'(expN));
    chk(rdBlockBad == 0, "R8 store held during read miss", 32'(rdBlockBad), 0);
    cpuWrite(8'h72, 16'h9999, w);
    waitDrain();
    checkLog();

    // R10 / R7: read with empty buffer
    cpuRead(8'h72, rd, lw);
    chk(rd == 16'h9999, "R10 direct read sees drained store", 32'(rd), 32'h9999);
    cpuRead(8'h05, rd, lw);
    chk(rd == (16'h0005 ^ 16'hA5A5), "R7 read data from memory", 32'(rd), 32'(16'h0005 ^ 16'hA5A5));
    chk(logN == expN, "R7 read issues no write", 32'(logN), 32'(expN));

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule